// File: doc/BRIEF.md
# Four-Channel Compare Timer with Reset Watchdog

This block is a register-mapped system timer. A 32-bit up-counter advances on every clock where the count-enable tick is high. Four 32-bit compare registers are each checked against the counter value. When the counter reaches a compare value and that channel is enabled, the block latches an event bit and drives a level interrupt for the channel. Software clears the event by writing a one to its bit.

Channel 3 has a second role as a watchdog. Software arms it by setting bit 0 of the watchdog register. If the counter then reaches the channel-3 compare value, the block emits a one-cycle reset request and disarms itself. The interrupt enable plays no part in this.

The register bus is synchronous, with a byte address, a write strobe, write data, a read strobe and registered read data. Dividing the tick rate down is the job of the logic that drives `tick`.

Top module: `os_match_timer`

## Requirements
- R1: After reset every mapped register reads zero, `irq_o` is 0 and `wdt_rst_req_o` is 0.
- R2: The counter (address 0x10) rises by exactly one on each clock edge where `tick` is high and holds its value otherwise.
- R3: A bus write to 0x10 loads the counter and does not count as a match by itself. The counter wraps from 0xFFFFFFFF to 0 and keeps comparing after the wrap.
- R4: Compare register i sits at address 4*i (i = 0..3). An advance that brings the counter to that value sets status bit i (status at 0x14, bit i = channel i) and `irq_o[i]` on the same edge, provided enable bit i is set.
- R5: If enable bit i is clear, a match on channel i sets neither status bit i nor `irq_o[i]`.
- R6: Writing the status register clears every bit written as 1, together with its interrupt line. Bits written as 0 keep their value.
- R7: The interrupt-enable register at 0x1C stores the low 12 bits of the write data and reads back as `wdata & 0xFFF`.
- R8: When bit 0 of the watchdog register (0x18) is set and a channel-3 match occurs, `wdt_rst_req_o` is high for exactly one cycle and the watchdog register clears to zero. This does not depend on the enable bits. With bit 0 clear, a channel-3 match gives no request.
- R9: Read data appears on `bus_rdata` one cycle after the `bus_rd` strobe. Any address not listed above reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; counter advances when high |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 4 | Per-channel interrupt, high while its status bit is set |
| wdt_rst_req_o | output | 1 | One-cycle reset request from the watchdog |

## Verification
The counter is the shared state, so a wrong count shows up in two places. A direct counter read exposes it one cycle after the strobe. A wrong count also moves every match, and `irq_o` or the reset pulse then rise on the wrong edge or never rise. A stuck or wrongly gated status bit is visible on `irq_o` in the cycle right after the edge that should have changed it. A watchdog that fails to disarm shows only at the next channel-3 match, as a second request. The scoreboard therefore reads the watchdog register back right after each pulse.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
   localparam int unsigned ADDR_W = 8;
   localparam logic [ADDR_W-1:0] A_COUNT = 8'h10;
   localparam logic [ADDR_W-1:0] A_STAT  = 8'h14;
   localparam logic [ADDR_W-1:0] A_WDOG  = 8'h18;
   localparam logic [ADDR_W-1:0] A_IEN   = 8'h1C;

   // compare register i lives at byte address 4*i
   function automatic logic [ADDR_W-1:0] cmp_addr(input int unsigned idx);
      return ADDR_W'(idx * 4);
   endfunction
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cnt_nxt,
   output logic         adv
);
   // a software load wins over the tick and is not itself an advance
   assign adv     = tick & ~ld;
   assign cnt_nxt = cnt_q + W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (ld)  cnt_q <= ld_val;
      else if (adv) cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/ostmr_chan.sv
module ostmr_chan #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] cnt_nxt,
   input  logic         adv,
   output logic [W-1:0] cmp_q,
   output logic         hit
);
   always_ff @(posedge clk) begin
      if (!rst_n)  cmp_q <= '0;
      else if (wr) cmp_q <= wdata;
   end

   // the match is judged on the value the counter is about to take
   assign hit = adv & (cnt_nxt == cmp_q);
endmodule

// File: rtl/ostmr_evt.sv
module ostmr_evt #(
   parameter int unsigned NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set_v,
   input  logic [NCH-1:0] clr_v,
   output logic [NCH-1:0] stat_q
);
   // a new event in the same cycle as its clear is kept
   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_v) | set_v;
   end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
   import ostmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned NCH    = 4,
   parameter int unsigned IEN_W  = 12,
   parameter int unsigned WDG_CH = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic [NCH-1:0]    irq_o,
   output logic              wdt_rst_req_o
);
   generate
      if (NCH < 1 || NCH > 4) begin : g_bad_nch
         $error("NCH must be 1..4 to fit the compare address window");
      end
      if (WDG_CH >= NCH) begin : g_bad_wdg
         $error("WDG_CH must name an existing channel");
      end
      if (IEN_W < NCH || IEN_W > CNT_W) begin : g_bad_ien
         $error("IEN_W must cover all channels and fit the data width");
      end
   endgenerate

   logic               wr_cnt, wr_stat, wr_wdog, wr_ien;
   logic [CNT_W-1:0]   cnt_q, cnt_nxt;
   logic               adv;
   logic [CNT_W-1:0]   cmp_q [NCH];
   logic [NCH-1:0]     hit;
   logic [IEN_W-1:0]   ien_q;
   logic [NCH-1:0]     ien_lo;
   logic [NCH-1:0]     stat_q;
   logic [CNT_W-1:0]   wdg_q;
   logic               wdg0;
   logic               rst_req_q;
   logic [CNT_W-1:0]   rd_mux;
   logic [CNT_W-1:0]   rdata_q;

   assign wr_cnt  = bus_wr && (bus_addr == A_COUNT);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_wdog = bus_wr && (bus_addr == A_WDOG);
   assign wr_ien  = bus_wr && (bus_addr == A_IEN);

   ostmr_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .ld      (wr_cnt),
      .ld_val  (bus_wdata),
      .cnt_q   (cnt_q),
      .cnt_nxt (cnt_nxt),
      .adv     (adv)
   );

   for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      logic wr_cmp;
      assign wr_cmp = bus_wr && (bus_addr == cmp_addr(gi));
      ostmr_chan #(.W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr      (wr_cmp),
         .wdata   (bus_wdata),
         .cnt_nxt (cnt_nxt),
         .adv     (adv),
         .cmp_q   (cmp_q[gi]),
         .hit     (hit[gi])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ien_q <= '0;
      else if (wr_ien) ien_q <= bus_wdata[IEN_W-1:0];
   end
   assign ien_lo = ien_q[NCH-1:0];

   ostmr_evt #(.NCH(NCH)) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_v  (hit & ien_lo),
      .clr_v  (wr_stat ? bus_wdata[NCH-1:0] : '0),
      .stat_q (stat_q)
   );
   assign irq_o = stat_q;

   // watchdog: a firing match disarms even against a same-cycle write
   assign wdg0 = wdg_q[0];
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wdg_q     <= '0;
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= hit[WDG_CH] & wdg0;
         if (hit[WDG_CH] && wdg0) wdg_q <= '0;
         else if (wr_wdog)        wdg_q <= bus_wdata;
      end
   end
   assign wdt_rst_req_o = rst_req_q;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == cmp_addr(i)) rd_mux = cmp_q[i];
      end
      case (bus_addr)
         A_COUNT: rd_mux = cnt_q;
         A_STAT:  rd_mux = CNT_W'(stat_q);
         A_WDOG:  rd_mux = wdg_q;
         A_IEN:   rd_mux = CNT_W'(ien_q);
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end
   assign bus_rdata = rdata_q;
endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk
   import ostmr_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned NCH   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [CNT_W-1:0]  bus_wdata,
   input logic [NCH-1:0]    irq_o,
   input logic              wdt_rst_req_o,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [NCH-1:0]    ien_lo,
   input logic              wdg0
);
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(bus_wr && bus_addr == A_COUNT)) |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R2

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !bus_wr) |=> $stable(cnt_q)); // R2

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((irq_o & ~$past(irq_o)) & ~$past(ien_lo)) == '0); // R5

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_STAT) |=> (irq_o & $past(irq_o)) == $past(irq_o)); // R6

   AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_STAT && !tick) |=> (irq_o & $past(bus_wdata[NCH-1:0])) == '0); // R6

   AST_WDG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req_o |=> !wdt_rst_req_o); // R8

   AST_WDG_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req_o |-> $past(wdg0)); // R8

   AST_WDG_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req_o |-> !wdg0); // R8
endmodule

bind os_match_timer ostmr_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick          (tick),
   .bus_wr        (bus_wr),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .irq_o         (irq_o),
   .wdt_rst_req_o (wdt_rst_req_o),
   .cnt_q         (cnt_q),
   .ien_lo        (ien_lo),
   .wdg0          (wdg0)
);

// File: tb/os_match_timer_bench.sv
module os_match_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq_o;
   logic        wdt_rst_req_o;

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t exp_q[$];

   os_match_timer u_os_match_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .bus_addr      (bus_addr),
      .bus_wr        (bus_wr),
      .bus_rd        (bus_rd),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .irq_o         (irq_o),
      .wdt_rst_req_o (wdt_rst_req_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // driver: pushes the expected value, monitor compares it
   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      rd_item_t it;
      it.exp = exp; it.tag = tag;
      @(negedge clk);
      exp_q.push_back(it);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   // monitor: rdata is registered at the edge that sees bus_rd
   initial begin
      forever begin
         @(posedge clk);
         if (bus_rd) begin
            rd_item_t it;
            @(negedge clk);
            it = exp_q.pop_front();
            chk(it.tag, bus_rdata, it.exp);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired (all requirements) act=running exp=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq after reset", 32'(irq_o), 32'h0);
      chk("R1 wdt after reset", 32'(wdt_rst_req_o), 32'h0);
      rd(8'h10, 32'h0, "R1 counter");
      rd(8'h00, 32'h0, "R1 cmp0");
      rd(8'h0C, 32'h0, "R1 cmp3");
      rd(8'h14, 32'h0, "R1 status");
      rd(8'h18, 32'h0, "R1 watchdog");
      rd(8'h1C, 32'h0, "R1 enable");

      // R7 enable masking
      wr(8'h1C, 32'hFFFF_F00F);
      rd(8'h1C, 32'h0000_000F, "R7 enable mask");

      // R2 counting, holds while tick low
      ticks(7);
      rd(8'h10, 32'd7, "R2 count 7");
      rd(8'h10, 32'd7, "R2 hold");

      // R4 enabled match
      wr(8'h00, 32'h20);
      ticks(25);
      chk("R4 irq ch0 on match", 32'(irq_o), 32'h1);
      rd(8'h14, 32'h1, "R4 status ch0");

      // R5 disabled channel ignored
      wr(8'h1C, 32'h005);
      wr(8'h04, 32'h25);
      wr(8'h08, 32'h28);
      ticks(5);
      chk("R5 ch1 disabled no irq", 32'(irq_o), 32'h1);
      ticks(3);
      chk("R4 ch2 enabled irq", 32'(irq_o), 32'h5);
      rd(8'h14, 32'h5, "R5 status without ch1");

      // R6 write-one-to-clear
      wr(8'h14, 32'hC);
      chk("R6 clear ch2", 32'(irq_o), 32'h1);
      wr(8'h14, 32'h0);
      rd(8'h14, 32'h1, "R6 zeros keep bits");
      wr(8'h14, 32'h1);
      chk("R6 clear ch0", 32'(irq_o), 32'h0);

      // R3 load equal to compare value is not a match
      wr(8'h10, 32'h28);
      chk("R3 load no match irq", 32'(irq_o), 32'h0);
      rd(8'h14, 32'h0, "R3 load no match status");
      rd(8'h10, 32'h28, "R3 load value");

      // R3 wrap and compare after wrap
      wr(8'h00, 32'h1);
      wr(8'h10, 32'hFFFF_FFFE);
      ticks(2);
      chk("R3 wrap no early match", 32'(irq_o), 32'h0);
      rd(8'h10, 32'h0, "R3 wrapped to zero");
      ticks(1);
      chk("R3 match after wrap", 32'(irq_o), 32'h1);
      wr(8'h14, 32'hF);

      // R8 watchdog fires with enables off
      wr(8'h1C, 32'h0);
      wr(8'h0C, 32'h50);
      wr(8'h18, 32'h1);
      wr(8'h10, 32'h4B);
      ticks(5);
      chk("R8 reset pulse", 32'(wdt_rst_req_o), 32'h1);
      @(negedge clk);
      chk("R8 pulse one cycle", 32'(wdt_rst_req_o), 32'h0);
      rd(8'h18, 32'h0, "R8 watchdog disarmed");
      rd(8'h14, 32'h0, "R8 no status with enable off");

      // R8 unarmed: no request
      wr(8'h10, 32'h4B);
      ticks(5);
      chk("R8 unarmed no pulse", 32'(wdt_rst_req_o), 32'h0);

      // R9 readback and unmapped address
      rd(8'h24, 32'h0, "R9 unmapped");
      rd(8'h04, 32'h25, "R9 cmp1 readback");
      rd(8'h0C, 32'h50, "R9 cmp3 readback");

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule